// File: doc/BRIEF.md
# ADC Result Byte Handshake Sequencer

This block sits between the digital controller of an integrating A/D converter and a byte-wide receiver such as a UART transmit buffer. It holds the latest conversion result (magnitude, polarity and overrange) and presents it on byte lanes. The receiver can fetch those lanes in two ways.

In direct mode the receiver owns the bus. It drives an active-low chip enable and one active-low enable per byte, and a lane's outputs turn on only while both are low.

In handshake mode the block becomes the bus master. It drives the load strobe and the byte-enable flags itself and sends the bytes one at a time, pacing each one on a send-enable input. The block runs on a system clock at twice the converter clock. It generates the converter clock phase internally, so it can sample send-enable on one converter edge and move its strobes on the other. While a transfer is running, it refuses new result latches from the controller.

Top module: `adc_byte_handshake`

## Requirements
- R1: After reset the block is in direct mode. `ctl_oe`, `latch_inhibit` and all `byte_oe` bits are low, `ce_ld_out` and `ben_out` are all ones, and `lane_data` is zero.
- R2: In direct mode `ctl_oe` is low, and `byte_oe[k]` is high exactly when `ce_ld_in` is low and `ben_in[k]` is low.
- R3: When `latch_req` is high in direct mode, the result is captured and appears on `lane_data` after the next edge. Lane 0 (`lane_data[7:0]`) is the high byte, with polarity at bit 7 and overrange at bit 6. Bits 5:0 of lane 0 are zero in the 16-bit variant and hold result bits 13:8 in the 14-bit variant. In the 16-bit variant lane 1 holds result bits 15:8 and lane 2 holds bits 7:0. In the 14-bit variant lane 1 holds bits 7:0. A latch taken with `mode_in` low does not start a transfer.
- R4: A latch taken while `mode_in` is high captures the result and enters handshake mode on the same edge.
- R5: A low-to-high change of `mode_in` in direct mode enters handshake mode on the next edge, without any latch. A change that arrives in the same cycle as a latch also captures that latch.
- R6: In handshake mode `latch_inhibit` and `ctl_oe` are high. Latch requests are discarded and `lane_data` does not change. `mode_in` changes have no effect.
- R7: `cclk` is the internal converter clock. When it is high, the next system edge is a falling converter edge. Send-enable is sampled only on falling converter edges. After a sample that sees it high, the following rising edge drives `ce_ld_out` low, drives the current `ben_out` bit low and sets its `byte_oe` bit.
- R8: `ce_ld_out` stays low for exactly two system cycles (one converter period). With send-enable held high, a byte's `byte_oe` stays on for three system cycles and its `ben_out` bit stays low for four.
- R9: While send-enable stays low, the current byte's enable and data outputs remain on indefinitely.
- R10: Bytes are sent in lane order 0, 1, 2 (high, middle, low) for the 16-bit variant. The next byte's enable and strobe fall on the same edge that the previous byte's enable rises. At most one `byte_oe` bit is set in handshake mode.
- R11: Handshake mode ends on the rising converter edge after the last byte is acknowledged. `ctl_oe` and `latch_inhibit` drop together, and a later latch is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the converter clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_req | input | 1 | Result latch pulse from the conversion controller |
| res_pol | input | 1 | Polarity of the new result (1 = positive) |
| res_ovr | input | 1 | Overrange flag of the new result |
| res_data | input | RES_BITS | Result magnitude |
| mode_in | input | 1 | Output mode select / handshake trigger |
| send_en | input | 1 | Receiver ready to take a byte |
| ce_ld_in | input | 1 | Direct-mode chip enable, active low |
| ben_in | input | NB | Direct-mode byte enables, active low, bit 0 = high byte |
| ce_ld_out | output | 1 | Handshake load strobe, active low |
| ben_out | output | NB | Handshake byte-enable flags, active low |
| ctl_oe | output | 1 | Output enable for the strobe and byte-enable pins |
| cclk | output | 1 | Internal converter clock phase |
| byte_oe | output | NB | Per-lane data output enable |
| lane_data | output | 8*NB | Byte lanes, lane k at bits 8k+7:8k |
| latch_inhibit | output | 1 | High while new result latches are refused |

## Verification
The hardest situation to reach is a transfer that stalls in mid-byte while other events arrive. In that case a latch request and a mode drop land during handshake mode, and send-enable falls after the strobe but before the acknowledge. The bench enters handshake mode through a bare rising edge on `mode_in`, holds send-enable low, and fires a latch with a different result while the block waits. It then releases send-enable only long enough for the first strobe and stalls the byte before completing the transfer. A full-speed transfer is recorded cycle by cycle so that strobe, enable and data windows are measured relative to the first strobe, whatever converter phase entry happened on.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

    typedef enum logic [2:0] {
        ST_DIRECT,
        ST_WAIT,
        ST_ARM,
        ST_ON,
        ST_ON2,
        ST_HOLD,
        ST_ACK
    } hs_state_t;

    typedef struct packed {
        logic        pol;
        logic        ovr;
        logic [15:0] mag;
    } result_t;

    function automatic int lane_count(int res_bits);
        return (res_bits == 16) ? 3 : 2;
    endfunction

    function automatic logic [7:0] lane_byte(result_t r, int res_bits, int k);
        logic [7:0] b;
        if (k == 0) begin
            if (res_bits == 16) b = {r.pol, r.ovr, 6'b000000};
            else                b = {r.pol, r.ovr, r.mag[13:8]};
        end else if (k == lane_count(res_bits) - 1) begin
            b = r.mag[7:0];
        end else begin
            b = r.mag[15:8];
        end
        return b;
    endfunction

endpackage

// File: rtl/adc_hs_result_latch.sv
module adc_hs_result_latch
    import adc_hs_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                pol,
    input  logic                ovr,
    input  logic [RES_BITS-1:0] data,
    output result_t             q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q.pol <= pol;
            q.ovr <= ovr;
            q.mag <= 16'(data);
        end
    end
endmodule

// File: rtl/adc_hs_seq.sv
module adc_hs_seq
    import adc_hs_pkg::*;
#(
    parameter int NB = 3,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          latch_req,
    input  logic          mode_in,
    input  logic          send_en,
    output logic          hs_active,
    output logic          cclk,
    output logic          ce_n,
    output logic [NB-1:0] ben_n,
    output logic [NB-1:0] lane_on
);
    hs_state_t     st;
    logic [IW-1:0] idx;
    logic          cclk_q;
    logic          mode_d;
    logic          is_fall;
    logic          start;

    assign is_fall = cclk_q;
    assign start   = mode_in & (latch_req | ~mode_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            cclk_q <= 1'b0;
            mode_d <= 1'b0;
            st     <= ST_DIRECT;
            idx    <= '0;
        end else begin
            cclk_q <= ~cclk_q;
            mode_d <= mode_in;
            unique case (st)
                ST_DIRECT: if (start) begin
                    st  <= ST_WAIT;
                    idx <= '0;
                end
                ST_WAIT:   if (is_fall && send_en) st <= ST_ARM;
                ST_ARM:    st <= ST_ON;
                ST_ON:     st <= ST_ON2;
                ST_ON2:    st <= ST_HOLD;
                ST_HOLD:   if (is_fall && send_en) st <= ST_ACK;
                ST_ACK: begin
                    if (idx == IW'(NB - 1)) begin
                        st <= ST_DIRECT;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= ST_ON;
                    end
                end
                default:   st <= ST_DIRECT;
            endcase
        end
    end

    always_comb begin
        hs_active = (st != ST_DIRECT);
        cclk      = cclk_q;
        ce_n      = ~((st == ST_ON) || (st == ST_ON2));
        ben_n     = '1;
        lane_on   = '0;
        if (st == ST_ON || st == ST_ON2 || st == ST_HOLD || st == ST_ACK)
            ben_n[idx] = 1'b0;
        if (st == ST_ON || st == ST_ON2 || st == ST_HOLD)
            lane_on[idx] = 1'b1;
    end
endmodule

// File: rtl/adc_hs_lane_gate.sv
module adc_hs_lane_gate #(
    parameter int NB = 3
) (
    input  logic          hs_active,
    input  logic          hs_ce_n,
    input  logic [NB-1:0] hs_ben_n,
    input  logic [NB-1:0] hs_lane_on,
    input  logic          ce_ld_in,
    input  logic [NB-1:0] ben_in,
    output logic          ce_ld_out,
    output logic [NB-1:0] ben_out,
    output logic [NB-1:0] byte_oe
);
    assign ce_ld_out = hs_active ? hs_ce_n  : 1'b1;
    assign ben_out   = hs_active ? hs_ben_n : '1;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign byte_oe[k] = hs_active ? hs_lane_on[k] : (~ce_ld_in & ~ben_in[k]);
    end
endmodule

// File: rtl/adc_byte_handshake.sv
module adc_byte_handshake
    import adc_hs_pkg::*;
#(
    parameter int RES_BITS = 16,
    localparam int NB = lane_count(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                latch_req,
    input  logic                res_pol,
    input  logic                res_ovr,
    input  logic [RES_BITS-1:0] res_data,
    input  logic                mode_in,
    input  logic                send_en,
    input  logic                ce_ld_in,
    input  logic [NB-1:0]       ben_in,
    output logic                ce_ld_out,
    output logic [NB-1:0]       ben_out,
    output logic                ctl_oe,
    output logic                cclk,
    output logic [NB-1:0]       byte_oe,
    output logic [8*NB-1:0]     lane_data,
    output logic                latch_inhibit
);
    result_t       res_q;
    logic          hs_active;
    logic          hs_ce_n;
    logic [NB-1:0] hs_ben_n;
    logic [NB-1:0] hs_lane_on;

    adc_hs_result_latch #(.RES_BITS(RES_BITS)) latch_i (
        .clk  (clk),
        .rst  (rst),
        .load (latch_req & ~hs_active),
        .pol  (res_pol),
        .ovr  (res_ovr),
        .data (res_data),
        .q    (res_q)
    );

    adc_hs_seq #(.NB(NB)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .latch_req (latch_req),
        .mode_in   (mode_in),
        .send_en   (send_en),
        .hs_active (hs_active),
        .cclk      (cclk),
        .ce_n      (hs_ce_n),
        .ben_n     (hs_ben_n),
        .lane_on   (hs_lane_on)
    );

    adc_hs_lane_gate #(.NB(NB)) gate_i (
        .hs_active  (hs_active),
        .hs_ce_n    (hs_ce_n),
        .hs_ben_n   (hs_ben_n),
        .hs_lane_on (hs_lane_on),
        .ce_ld_in   (ce_ld_in),
        .ben_in     (ben_in),
        .ce_ld_out  (ce_ld_out),
        .ben_out    (ben_out),
        .byte_oe    (byte_oe)
    );

    for (genvar k = 0; k < NB; k++) begin : g_fmt
        assign lane_data[8*k +: 8] = lane_byte(res_q, RES_BITS, k);
    end

    assign ctl_oe        = hs_active;
    assign latch_inhibit = hs_active;
endmodule

// File: rtl/adc_hs_checker.sv
module adc_hs_checker #(
    parameter int NB = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            ce_ld_in,
    input logic            ce_ld_out,
    input logic [NB-1:0]   ben_out,
    input logic            ctl_oe,
    input logic            cclk,
    input logic [NB-1:0]   byte_oe,
    input logic [8*NB-1:0] lane_data,
    input logic            latch_inhibit
);
    // R8: strobe low for exactly one converter period
    a_r8_ce_one_period: assert property (@(posedge clk) disable iff (rst)
        $fell(ce_ld_out) |=> !ce_ld_out ##1 ce_ld_out);

    // R7: strobe falls only on a rising converter edge
    a_r7_strobe_on_rise: assert property (@(posedge clk) disable iff (rst)
        $fell(ce_ld_out) |-> cclk);

    // R6: no latch accepted while a transfer runs
    a_r6_no_latch_in_hs: assert property (@(posedge clk) disable iff (rst)
        latch_inhibit |=> $stable(lane_data));

    // R10: at most one lane driven in handshake mode
    a_r10_one_lane: assert property (@(posedge clk) disable iff (rst)
        ctl_oe |-> $onehot0(byte_oe));

    // R8: a driven lane always has its enable flag low
    a_r8_oe_with_ben: assert property (@(posedge clk) disable iff (rst)
        ctl_oe |-> ((byte_oe & ben_out) == '0));

    // R2: chip enable high closes every lane in direct mode
    a_r2_direct_gate: assert property (@(posedge clk) disable iff (rst)
        (!ctl_oe && ce_ld_in) |-> (byte_oe == '0));

    // R11: handshake mode ends on a rising converter edge
    a_r11_exit_on_rise: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_oe) |-> cclk);
endmodule

bind adc_byte_handshake adc_hs_checker #(.NB(NB)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .ce_ld_in      (ce_ld_in),
    .ce_ld_out     (ce_ld_out),
    .ben_out       (ben_out),
    .ctl_oe        (ctl_oe),
    .cclk          (cclk),
    .byte_oe       (byte_oe),
    .lane_data     (lane_data),
    .latch_inhibit (latch_inhibit)
);

// File: tb/adc_byte_handshake_tb_top.sv
module adc_byte_handshake_tb_top;
    localparam int CLK_P = 10;
    localparam int NB    = 3;
    localparam int TR    = 20;

    // {ce, ben[2:0], expected byte_oe[2:0]}
    localparam logic [6:0] DVEC [8] = '{
        7'b1_000_000,
        7'b0_111_000,
        7'b0_110_001,
        7'b0_101_010,
        7'b0_011_100,
        7'b0_000_111,
        7'b1_110_000,
        7'b0_010_101
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          latch_req = 1'b0;
    logic          res_pol = 1'b0;
    logic          res_ovr = 1'b0;
    logic [15:0]   res_data = '0;
    logic          mode_in = 1'b0;
    logic          send_en = 1'b0;
    logic          ce_ld_in = 1'b1;
    logic [NB-1:0] ben_in = '1;
    logic          ce_ld_out;
    logic [NB-1:0] ben_out;
    logic          ctl_oe;
    logic          cclk;
    logic [NB-1:0] byte_oe;
    logic [8*NB-1:0] lane_data;
    logic          latch_inhibit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic          t_ce  [TR];
    logic [NB-1:0] t_ben [TR];
    logic [NB-1:0] t_oe  [TR];
    logic          t_ctl [TR];
    logic          t_inh [TR];
    logic          t_clk [TR];
    logic [23:0]   t_lane[TR];

    always #(CLK_P/2) clk = ~clk;

    adc_byte_handshake dut_i (
        .clk(clk), .rst(rst), .latch_req(latch_req), .res_pol(res_pol),
        .res_ovr(res_ovr), .res_data(res_data), .mode_in(mode_in),
        .send_en(send_en), .ce_ld_in(ce_ld_in), .ben_in(ben_in),
        .ce_ld_out(ce_ld_out), .ben_out(ben_out), .ctl_oe(ctl_oe),
        .cclk(cclk), .byte_oe(byte_oe), .lane_data(lane_data),
        .latch_inhibit(latch_inhibit)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_latch(logic p, logic o, logic [15:0] d);
        latch_req = 1'b1; res_pol = p; res_ovr = o; res_data = d;
        tick();
        latch_req = 1'b0;
    endtask

    task automatic wait_exit();
        for (int i = 0; i < 100 && ctl_oe; i++) tick();
    endtask

    initial begin
        int i0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 ctl_oe", ctl_oe, 0);
        chk("R1 inhibit", latch_inhibit, 0);
        chk("R1 lanes", lane_data, 0);
        chk("R1 byte_oe", byte_oe, 0);
        chk("R1 strobes", {ce_ld_out, ben_out}, 4'hF);

        // R3 direct latch, mode low: formats, no transfer
        do_latch(1'b0, 1'b1, 16'h1234);
        chk("R3 lanes", lane_data, 24'h341240);
        tick();
        chk("R3 no hs", ctl_oe, 0);

        // R2 direct gating table
        for (int v = 0; v < 8; v++) begin
            ce_ld_in = DVEC[v][6];
            ben_in   = DVEC[v][5:3];
            #1;
            chk("R2 byte_oe", byte_oe, DVEC[v][2:0]);
            chk("R2 ctl_oe", ctl_oe, 0);
            tick();
        end
        ce_ld_in = 1'b1; ben_in = '1;

        // R4 entry on latch with mode high, full-speed transfer trace
        mode_in = 1'b1; send_en = 1'b1;
        do_latch(1'b1, 1'b0, 16'hA5C3);
        mode_in = 1'b0;
        chk("R4 ctl_oe", ctl_oe, 1);
        chk("R4 lanes", lane_data, 24'hC3A580);
        for (int i = 0; i < TR; i++) begin
            t_ce[i] = ce_ld_out; t_ben[i] = ben_out; t_oe[i] = byte_oe;
            t_ctl[i] = ctl_oe; t_inh[i] = latch_inhibit; t_clk[i] = cclk;
            t_lane[i] = lane_data;
            tick();
        end
        i0 = -1;
        for (int i = TR - 1; i >= 0; i--) if (!t_ce[i]) i0 = i;
        chk("R7 strobe seen early", (i0 >= 0 && i0 <= 4) ? 1 : 0, 1);
        if (i0 >= 0 && i0 <= 4) begin
            chk("R7 on rising edge", t_clk[i0], 1);
            chk("R7 first ben", t_ben[i0], 3'b110);
            chk("R7 first oe", t_oe[i0], 3'b001);
            chk("R8 ce low 2", {t_ce[i0+1], t_ce[i0+2]}, 2'b01);
            chk("R8 oe 3 cycles", {t_oe[i0+2], t_oe[i0+3]}, 6'b001_000);
            chk("R8 ben 4 cycles", t_ben[i0+3], 3'b110);
            chk("R10 mid byte", {t_ben[i0+4], t_oe[i0+4], t_ce[i0+4]}, 7'b101_010_0);
            chk("R10 low byte", {t_ben[i0+8], t_oe[i0+8], t_ce[i0+8]}, 7'b011_100_0);
            chk("R11 last ben", {t_ctl[i0+11], t_ben[i0+11]}, 4'b1_011);
            chk("R11 exit", {t_ctl[i0+12], t_inh[i0+12]}, 2'b00);
            chk("R6 lanes held", t_lane[i0+8], 24'hC3A580);
        end
        send_en = 1'b0;
        wait_exit();

        // R5 entry on bare mode rise; R6 discard latch and ignore mode
        tick();
        mode_in = 1'b1;
        tick();
        chk("R5 rise entry", {ctl_oe, latch_inhibit}, 2'b11);
        do_latch(1'b0, 1'b1, 16'hFFFF);
        mode_in = 1'b0;
        repeat (5) tick();
        chk("R6 latch discarded", lane_data, 24'hC3A580);
        chk("R6 mode ignored", ctl_oe, 1);
        chk("R7 no send no strobe", {ce_ld_out, byte_oe}, 4'b1_000);

        // R9 stall mid-byte
        send_en = 1'b1;
        for (int i = 0; i < 10 && ce_ld_out; i++) tick();
        send_en = 1'b0;
        repeat (6) tick();
        chk("R9 held oe", byte_oe, 3'b001);
        chk("R9 held ben", ben_out, 3'b110);
        send_en = 1'b1;
        wait_exit();
        send_en = 1'b0;
        chk("R11 cleared", {ctl_oe, latch_inhibit}, 2'b00);

        // R5 mode rise in the same cycle as a latch; R11 latch accepted again
        tick();
        mode_in = 1'b1;
        do_latch(1'b0, 1'b0, 16'h0F0F);
        chk("R5 latch with rise", lane_data, 24'h0F0F00);
        chk("R5 hs entered", ctl_oe, 1);
        mode_in = 1'b0;
        send_en = 1'b1;
        wait_exit();
        chk("R11 final exit", ctl_oe, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule